// File: doc/BRIEF.md
# Bit-Addressed GPIO Port Register Block

This block is the register front end of a 32-pin general-purpose I/O port. Software reaches it through a small memory-mapped bus with single-cycle writes and registered reads. It drives a per-pin output enable and a per-pin output value toward the pads. It also samples the pad inputs through a two-stage synchronizer so that software can read them.

A pin changes direction through one of two write-one-to-act registers: one turns the selected pins into outputs and the other turns them into inputs. Output values are written through two half-port registers. In each of these, the upper sixteen bits of the written word select which pins take the new value from the lower sixteen bits. Any single pin can therefore be changed with one write and no read-modify-write. The output latch keeps its value while a pin is an input, so a level can be staged before the pin is turned into an output.

Top module: `pin_bank_regs`

## Requirements
- R1: After a synchronous active-low reset, every pin is an input (`pin_oe` all 0), every output data bit is 0 (`pin_out` all 0), and `bus_rdata` is 0.
- R2: A write to offset 0x00 sets `pin_oe[i]` to 1 for each bit i of the write data that is 1, in the cycle after the write edge. Pins whose data bit is 0 keep their direction.
- R3: A write to offset 0x04 sets `pin_oe[i]` to 0 for each bit i of the write data that is 1. Pins whose data bit is 0 keep their direction.
- R4: A write to offset 0x08 updates output latch bit i (pins 0 to 15) to write data bit i only where write data bit i+16 is 1. All other latch bits, including pins 16 to 31, are unchanged.
- R5: A write to offset 0x0C updates output latch bit 16+i (pins 16 to 31) to write data bit i only where write data bit i+16 is 1. All other latch bits, including pins 0 to 15, are unchanged.
- R6: `pin_out` always shows the output latch, whatever the direction. A value staged while a pin is an input appears together with `pin_oe` as soon as the pin becomes an output, and the value is kept when the pin returns to input.
- R7: A read of offset 0x04 returns the direction vector (1 means output) on `bus_rdata` one cycle after the read edge.
- R8: A read of offset 0x10 returns the pin levels after two synchronizer flops. A change on `pin_in` made before rising edge k is seen by a read sampled at edge k+2 and not by a read sampled at edge k+1.
- R9: Reads of any offset other than 0x04 and 0x10 (including 0x00, 0x08, 0x0C) return 0. `bus_rdata` is 0 in every cycle that follows an edge with no read.
- R10: Writes to offsets other than 0x00, 0x04, 0x08 and 0x0C (including 0x10) change neither direction nor output data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_rd_en | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_oe | output | 32 | Per-pin output enable, 1 = output |
| pin_out | output | 32 | Per-pin output value |

## Verification
On every cycle, the assertions check the effect of a write on the direction vector: the set and clear registers touch only the selected bits, and direction holds when neither is written. They check that each masked half-word write touches only its masked bits within its own half, and that read data is zero after any cycle without a read. The bench scenarios show the behaviour that needs a specific history: the staged output value that appears when a pin is enabled, the exact two-edge synchronizer delay on the level read, the zero read-back of write-only and unmapped offsets, and the absence of any effect from writes to read-only offsets.

// File: rtl/pin_bank_pkg.sv
// Package pin_bank_pkg
// Shared offsets and widths for the GPIO port register block.
// Assumes a byte-addressed bus with word-aligned 32-bit registers.
package pin_bank_pkg;
    localparam int BANK_ADDR_W = 8;
    localparam int BANK_DATA_W = 32;

    localparam logic [BANK_ADDR_W-1:0] OFS_DIR_SET  = 8'h00;
    localparam logic [BANK_ADDR_W-1:0] OFS_DIR_CLR  = 8'h04;
    localparam logic [BANK_ADDR_W-1:0] OFS_DATA_LO  = 8'h08;
    localparam logic [BANK_ADDR_W-1:0] OFS_DATA_HI  = 8'h0C;
    localparam logic [BANK_ADDR_W-1:0] OFS_LEVELS   = 8'h10;
endpackage

// File: rtl/pin_bank_sync.sv
// Module pin_bank_sync
// Two-flop synchronizer applied bitwise to the pad inputs.
// Assumes each bit is independent; no bus coherency across bits is given.
module pin_bank_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the asynchronous levels through two flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/pin_bank_dir.sv
// Module pin_bank_dir
// Direction vector updated by write-one-to-set and write-one-to-clear strobes.
// Assumes set_en and clr_en are never high together (one bus write per cycle).
module pin_bank_dir #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [WIDTH-1:0] sel_bits,
    output logic [WIDTH-1:0] dir_q
);
    // Hold the direction; OR in set bits or mask out clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (set_en) begin
            dir_q <= dir_q | sel_bits;
        end else if (clr_en) begin
            dir_q <= dir_q & ~sel_bits;
        end
    end
endmodule

// File: rtl/pin_bank_outdata.sv
// Module pin_bank_outdata
// Output data latch written in halves; each write word carries a mask in its
// upper half and new values in its lower half.
// Assumes WIDTH is even and the write word is WIDTH bits wide.
module pin_bank_outdata #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       half_wr,
    input  logic [WIDTH-1:0] wr_word,
    output logic [WIDTH-1:0] data_q
);
    localparam int HALF = WIDTH / 2;

    logic [HALF-1:0] wr_mask;
    logic [HALF-1:0] wr_vals;

    assign wr_mask = wr_word[WIDTH-1:HALF];
    assign wr_vals = wr_word[HALF-1:0];

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF-1:0] half_q;

        // Merge masked new values into this half of the latch.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                half_q <= '0;
            end else if (half_wr[h]) begin
                half_q <= (half_q & ~wr_mask) | (wr_vals & wr_mask);
            end
        end

        assign data_q[h*HALF +: HALF] = half_q;
    end
endmodule

// File: rtl/pin_bank_regs.sv
// Module pin_bank_regs
// Register front end of a 32-pin GPIO port: direction set/clear, masked
// half-port output writes, direction and synchronized level read-back.
// Assumes at most one of bus_wr_en / bus_rd_en per cycle matters per address;
// reads are registered with one cycle of latency, unmapped reads give zero.
module pin_bank_regs
    import pin_bank_pkg::*;
#(
    parameter int ADDR_W = BANK_ADDR_W,
    parameter int DATA_W = BANK_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_rd_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_oe,
    output logic [DATA_W-1:0] pin_out
);
    logic              hit_set;
    logic              hit_clr;
    logic [1:0]        hit_half;
    logic [DATA_W-1:0] levels;
    logic [DATA_W-1:0] rd_mux;

    // Decode write strobes per register.
    always_comb begin
        hit_set     = bus_wr_en && (bus_addr == ADDR_W'(OFS_DIR_SET));
        hit_clr     = bus_wr_en && (bus_addr == ADDR_W'(OFS_DIR_CLR));
        hit_half[0] = bus_wr_en && (bus_addr == ADDR_W'(OFS_DATA_LO));
        hit_half[1] = bus_wr_en && (bus_addr == ADDR_W'(OFS_DATA_HI));
    end

    pin_bank_dir #(.WIDTH(DATA_W)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (hit_set),
        .clr_en   (hit_clr),
        .sel_bits (bus_wdata),
        .dir_q    (pin_oe)
    );

    pin_bank_outdata #(.WIDTH(DATA_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_wr (hit_half),
        .wr_word (bus_wdata),
        .data_q  (pin_out)
    );

    pin_bank_sync #(.WIDTH(DATA_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (levels)
    );

    // Select read data for the two readable offsets.
    always_comb begin
        if (bus_addr == ADDR_W'(OFS_DIR_CLR)) begin
            rd_mux = pin_oe;
        end else if (bus_addr == ADDR_W'(OFS_LEVELS)) begin
            rd_mux = levels;
        end else begin
            rd_mux = '0;
        end
    end

    // Register read data; zero when no read was issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd_en) begin
            bus_rdata <= rd_mux;
        end else begin
            bus_rdata <= '0;
        end
    end
endmodule

// File: rtl/pin_bank_regs_chk.sv
// Module pin_bank_regs_chk
// Clocked properties over the ports of pin_bank_regs, bound to every instance.
// Assumes the offsets of pin_bank_pkg and a 32-bit data word split in halves.
module pin_bank_regs_chk
    import pin_bank_pkg::*;
#(
    parameter int ADDR_W = BANK_ADDR_W,
    parameter int DATA_W = BANK_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_rd_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pin_in,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] pin_out
);
    localparam int HALF = DATA_W / 2;

    logic wr_set, wr_clr, wr_lo, wr_hi;
    assign wr_set = bus_wr_en && (bus_addr == ADDR_W'(OFS_DIR_SET));
    assign wr_clr = bus_wr_en && (bus_addr == ADDR_W'(OFS_DIR_CLR));
    assign wr_lo  = bus_wr_en && (bus_addr == ADDR_W'(OFS_DATA_LO));
    assign wr_hi  = bus_wr_en && (bus_addr == ADDR_W'(OFS_DATA_HI));

    p_dir_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> pin_oe == ($past(pin_oe) | $past(bus_wdata)));

    p_dir_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata)));

    p_dir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_set || wr_clr) |=> $stable(pin_oe));

    p_low_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (pin_out[HALF-1:0] ==
            (($past(pin_out[HALF-1:0]) & ~$past(bus_wdata[DATA_W-1:HALF])) |
             ($past(bus_wdata[HALF-1:0]) & $past(bus_wdata[DATA_W-1:HALF]))))
            && $stable(pin_out[DATA_W-1:HALF]));

    p_high_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (pin_out[DATA_W-1:HALF] ==
            (($past(pin_out[DATA_W-1:HALF]) & ~$past(bus_wdata[DATA_W-1:HALF])) |
             ($past(bus_wdata[HALF-1:0]) & $past(bus_wdata[DATA_W-1:HALF]))))
            && $stable(pin_out[HALF-1:0]));

    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_lo || wr_hi) |=> $stable(pin_out));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> bus_rdata == '0);

    p_dir_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && bus_addr == ADDR_W'(OFS_DIR_CLR) && !bus_wr_en)
            |=> bus_rdata == $past(pin_oe));

    logic unused_in;
    assign unused_in = ^pin_in;
endmodule

bind pin_bank_regs pin_bank_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_rd_en (bus_rd_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
);

// File: tb/pin_bank_regs_test.sv
// Directed bench for pin_bank_regs: one task per scenario.
module pin_bank_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_oe;
    logic [31:0] pin_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pin_bank_regs uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr_en (bus_wr_en),
        .bus_rd_en (bus_rd_en),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] addr, logic [31:0] data);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(logic [7:0] addr, output logic [31:0] data);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = addr;
        @(negedge clk);
        bus_rd_en = 1'b0;
        data = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] rd;
        check("R1 pin_oe", pin_oe, 32'h0);
        check("R1 pin_out", pin_out, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        bus_read(8'h04, rd);
        check("R1 dir read", rd, 32'h0);
    endtask

    task automatic t_dir_set();
        bus_write(8'h00, 32'h0000_00F0);
        check("R2 set", pin_oe, 32'h0000_00F0);
        bus_write(8'h00, 32'h0001_0001);
        check("R2 set keeps others", pin_oe, 32'h0001_00F1);
    endtask

    task automatic t_dir_clr();
        logic [31:0] rd;
        bus_write(8'h04, 32'h0000_0030);
        check("R3 clear", pin_oe, 32'h0001_00C1);
        bus_read(8'h04, rd);
        check("R7 dir read", rd, 32'h0001_00C1);
        @(negedge clk);
        check("R9 idle rdata", bus_rdata, 32'h0);
    endtask

    task automatic t_data_low();
        bus_write(8'h08, 32'h00FF_A5A5);
        check("R4 low mask", pin_out, 32'h0000_00A5);
        bus_write(8'h08, 32'hFF00_1234);
        check("R4 low second", pin_out, 32'h0000_12A5);
    endtask

    task automatic t_data_high();
        bus_write(8'h0C, 32'hF00F_BEEF);
        check("R5 high mask", pin_out, 32'hB00F_12A5);
    endtask

    task automatic t_staged();
        bus_write(8'h0C, 32'h0010_0010);
        check("R6 staged out", pin_out, 32'hB01F_12A5);
        check("R6 still input", pin_oe & 32'h0010_0000, 32'h0);
        bus_write(8'h00, 32'h0010_0000);
        check("R6 enabled oe", pin_oe, 32'h0011_00C1);
        check("R6 enabled out", pin_out, 32'hB01F_12A5);
        bus_write(8'h04, 32'h0010_0000);
        check("R6 kept on input", pin_out, 32'hB01F_12A5);
    endtask

    task automatic t_levels();
        @(negedge clk);
        pin_in = 32'h5A5A_0F0F;
        repeat (4) @(negedge clk);
        pin_in = 32'hDEAD_BEEF;
        bus_rd_en = 1'b1; bus_addr = 8'h10;
        @(negedge clk);
        @(negedge clk);
        check("R8 not yet at k+1", bus_rdata, 32'h5A5A_0F0F);
        @(negedge clk);
        check("R8 visible at k+2", bus_rdata, 32'hDEAD_BEEF);
        bus_rd_en = 1'b0;
    endtask

    task automatic t_unmapped_read();
        logic [31:0] rd;
        bus_read(8'h00, rd);
        check("R9 read 0x00", rd, 32'h0);
        bus_read(8'h08, rd);
        check("R9 read 0x08", rd, 32'h0);
        bus_read(8'h0C, rd);
        check("R9 read 0x0C", rd, 32'h0);
        bus_read(8'h14, rd);
        check("R9 read 0x14", rd, 32'h0);
    endtask

    task automatic t_ignored_write();
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'hFFFF_FFFF);
        check("R10 oe unchanged", pin_oe, 32'h0001_00C1);
        check("R10 out unchanged", pin_out, 32'hB01F_12A5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_set();
        t_dir_clr();
        t_data_low();
        t_data_high();
        t_staged();
        t_levels();
        t_unmapped_read();
        t_ignored_write();
        repeat (2) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule